// File: doc/BRIEF.md
# SPI Register Slave with Busy Flag

This block is a SPI mode 0 target that gives a host access to eight byte-wide registers. They hold a memory address, a data byte, a command register, two 16-bit setpoints (each stored as a high byte and a low byte) and a sense delay. All SPI pins pass through synchronizers into the system clock domain. Every transaction is exactly two bytes long. The first byte selects the register and the direction. The second byte either carries the value to store or returns the register's contents.

Writing a command to the control register starts one of three back-end jobs: a memory read, a memory write, or a setpoint update. The block passes the job to a back-end through a one-cycle start pulse and waits for a done pulse. While the job runs, a busy flag is high. Whenever chip select is deasserted, MISO shows that flag, so the host can poll it between transactions without a dedicated pin.

Top module: `spi_reg_slave`

## Requirements
- R1: SPI mode 0, most significant bit first. If bit 7 of the first byte is 1, bits 6:0 select a register and the second byte is stored into it when the 16th rising SCLK edge is sampled.
- R2: If bit 7 of the first byte is 0, the selected register's value is shifted out on MISO during the second byte, most significant bit first, with each bit valid before the rising SCLK edge that samples it.
- R3: Register map: 0x00 address, 0x01 data, 0x02 control, 0x03/0x04 setpoint A high/low, 0x05/0x06 setpoint B high/low, 0x07 sense delay. Every other register select reads 0x00, and the control register always reads 0x00.
- R4: While chip select is high, MISO reports the busy flag: 1 while a job is in progress, 0 when idle.
- R5: Control bits 2:0 form a one-hot command: bit 0 is read, bit 1 is write, bit 2 is update, and bits 7:3 are ignored. A command value with zero or several of bits 2:0 set is ignored. An accepted command gives a single-cycle `be_start` with `be_op` set to 0 for read, 1 for write and 2 for update.
- R6: Busy rises only with an accepted command and falls only after `be_done`. A command written while busy is dropped.
- R7: On a memory read, `be_rdata` is loaded into the data register when `be_done` arrives.
- R8: On a memory write, `be_addr` and `be_wdata` take the address and data registers at the moment the command is accepted.
- R9: The setpoint byte registers read back what was written. `sp_a`/`sp_b` change only when an update command is accepted.
- R10: A transaction ended by chip select rising before the 16th rising edge changes no register and starts no job.
- R11: `sense_dly` follows the sense delay register as soon as that register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host; busy flag while cs_n is high |
| be_start | output | 1 | One-cycle job start pulse |
| be_op | output | 2 | Job kind: 0 read, 1 write, 2 update |
| be_addr | output | 8 | Memory address for the job |
| be_wdata | output | 8 | Memory write byte for the job |
| be_done | input | 1 | One-cycle job completion pulse |
| be_rdata | input | 8 | Memory read result, valid with be_done |
| sp_a | output | 16 | Applied setpoint A |
| sp_b | output | 16 | Applied setpoint B |
| sense_dly | output | 8 | Sense delay value |

## Verification
The bench sends a command while a long job is still running. A design that queued that command would show a second start pulse. It writes several control values with zero or multiple command bits set, which a careless decoder would turn into a job. It also ends transactions early, in the first byte and in the second byte. A slave that committed on a byte boundary rather than on the full frame would corrupt the data register or launch a job. Finally, it checks that the setpoint outputs stay unchanged after the setpoint bytes are written and move only after the update command. A design that applied setpoint bytes directly would fail that check.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        be_start,
  output logic [1:0]  be_op,
  output logic [7:0]  be_addr,
  output logic [7:0]  be_wdata,
  input  logic        be_done,
  input  logic [7:0]  be_rdata,
  output logic [15:0] sp_a,
  output logic [15:0] sp_b,
  output logic [7:0]  sense_dly
);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_UPD = 2'd2;
  localparam int FRAME = 16;
  localparam int HALF = FRAME / 2;

  logic [SYNC:0]   sclk_q;
  logic [SYNC-1:0] cs_q, mosi_q;
  logic [4:0] cnt;
  logic [6:0] rx;
  logic [7:0] hdr, tx, rd_val;
  logic [7:0] addr_r, data_r, spa_h, spa_l, spb_h, spb_l, dly_r;
  logic       busy;

  wire sel   = cs_q[SYNC-1];
  wire rise  = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  wire fall  = ~sclk_q[SYNC-1] & sclk_q[SYNC];
  wire mbit  = mosi_q[SYNC-1];
  wire [7:0] nxt = {rx, mbit};
  wire wr_fire = ~sel & rise & (cnt == 5'(FRAME - 1)) & hdr[7];
  wire cmd_one = (nxt[2:0] == 3'b001) | (nxt[2:0] == 3'b010) | (nxt[2:0] == 3'b100);
  wire cmd_ok  = wr_fire & (hdr[6:0] == 7'd2) & cmd_one & ~busy;

  assign miso = sel ? busy : ((cnt >= 5'(HALF)) ? tx[7] : 1'b0);
  assign sense_dly = dly_r;

  always_comb begin
    case (nxt[6:0])
      7'd0:    rd_val = addr_r;
      7'd1:    rd_val = data_r;
      7'd3:    rd_val = spa_h;
      7'd4:    rd_val = spa_l;
      7'd5:    rd_val = spb_h;
      7'd6:    rd_val = spb_l;
      7'd7:    rd_val = dly_r;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      cnt    <= '0;
      rx     <= '0;
      hdr    <= '0;
      tx     <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      if (sel) begin
        cnt <= '0;
      end else if (rise && cnt != 5'(FRAME)) begin
        cnt <= cnt + 5'd1;
        rx  <= nxt[6:0];
        if (cnt == 5'(HALF - 1)) begin
          hdr <= nxt;
          tx  <= rd_val;
        end
      end else if (fall && cnt > 5'(HALF) && cnt < 5'(FRAME)) begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0; data_r <= '0; dly_r <= '0;
      spa_h <= '0; spa_l <= '0; spb_h <= '0; spb_l <= '0;
      busy <= 1'b0; be_start <= 1'b0; be_op <= OP_RD;
      be_addr <= '0; be_wdata <= '0; sp_a <= '0; sp_b <= '0;
    end else begin
      be_start <= 1'b0;
      if (wr_fire) begin
        case (hdr[6:0])
          7'd0: addr_r <= nxt;
          7'd1: data_r <= nxt;
          7'd3: spa_h  <= nxt;
          7'd4: spa_l  <= nxt;
          7'd5: spb_h  <= nxt;
          7'd6: spb_l  <= nxt;
          7'd7: dly_r  <= nxt;
          default: ;
        endcase
      end
      if (cmd_ok) begin
        busy     <= 1'b1;
        be_start <= 1'b1;
        be_addr  <= addr_r;
        be_wdata <= data_r;
        if (nxt[0])      be_op <= OP_RD;
        else if (nxt[1]) be_op <= OP_WR;
        else begin
          be_op <= OP_UPD;
          sp_a  <= {spa_h, spa_l};
          sp_b  <= {spb_h, spb_l};
        end
      end else if (busy && be_done) begin
        busy <= 1'b0;
        if (be_op == OP_RD) data_r <= be_rdata;
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        be_start,
  input logic [1:0]  be_op,
  input logic        be_done,
  input logic        busy,
  input logic [15:0] sp_a,
  input logic [15:0] sp_b
);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) be_start |=> !be_start);
  // R5
  op_code_chk: assert property (@(posedge clk) disable iff (!rst_n) be_start |-> be_op != 2'd3);
  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) be_start |-> !$past(busy));
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> be_start);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(be_done));
  // R9
  setpoint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sp_a, sp_b}) |-> (be_start && be_op == 2'd2));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .be_start(be_start), .be_op(be_op),
  .be_done(be_done), .busy(busy), .sp_a(sp_a), .sp_b(sp_b)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int CLK_P = 10;
  localparam int HALF = 8 * CLK_P;
  localparam int NV = 16;
  // {is_write, reg, wdata, expected read}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h5A, 8'h00}, {1'b0, 8'h00, 8'h00, 8'h5A},
    {1'b1, 8'h03, 8'h12, 8'h00}, {1'b1, 8'h04, 8'h34, 8'h00},
    {1'b1, 8'h05, 8'hAB, 8'h00}, {1'b1, 8'h06, 8'hCD, 8'h00},
    {1'b1, 8'h07, 8'h77, 8'h00}, {1'b1, 8'h01, 8'h3C, 8'h00},
    {1'b0, 8'h03, 8'h00, 8'h12}, {1'b0, 8'h04, 8'h00, 8'h34},
    {1'b0, 8'h05, 8'h00, 8'hAB}, {1'b0, 8'h06, 8'h00, 8'hCD},
    {1'b0, 8'h07, 8'h00, 8'h77}, {1'b0, 8'h01, 8'h00, 8'h3C},
    {1'b0, 8'h02, 8'h00, 8'h00}, {1'b0, 8'h7F, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, be_start, be_done = 0;
  logic [1:0] be_op;
  logic [7:0] be_addr, be_wdata, be_rdata = 0, sense_dly;
  logic [15:0] sp_a, sp_b;
  int checks = 0, errors = 0, starts = 0, lat = 600;
  logic [7:0] mem [256];

  spi_reg_slave dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .be_start(be_start), .be_op(be_op), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_done(be_done), .be_rdata(be_rdata),
    .sp_a(sp_a), .sp_b(sp_b), .sense_dly(sense_dly));

  always #(CLK_P/2) clk = ~clk;

  logic pend = 0;
  int left = 0;
  logic [1:0] op_q;
  logic [7:0] a_q, d_q;
  always @(posedge clk) begin
    be_done <= 1'b0;
    if (be_start) begin
      starts++; pend = 1; left = lat; op_q = be_op; a_q = be_addr; d_q = be_wdata;
    end else if (pend) begin
      if (left <= 1) begin
        be_done <= 1'b1; be_rdata <= mem[a_q];
        if (op_q == 2'd1) mem[a_q] = d_q;
        pend = 0;
      end else left--;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                      output logic [7:0] rd);
    logic [15:0] fr = {b0, b1};
    rd = 0;
    cs_n = 0; #(HALF);
    for (int i = 15; i >= 16 - nbits; i--) begin
      mosi = fr[i]; #(HALF);
      if (i < 8) rd = {rd[6:0], miso};
      sclk = 1; #(HALF); sclk = 0;
    end
    #(HALF); cs_n = 1; #(2*HALF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] x;
    xfer(8'h80 | a, d, 16, x);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    xfer(a, 8'h00, 16, v);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && miso; k++) #(CLK_P);
  endtask

  initial begin
    #(20*CLK_P*10000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int s0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h55);
    mem[8'h20] = 8'h9E;
    #3;
    #(5*CLK_P) rst_n = 1; #(5*CLK_P);
    check("R4 reset busy", miso, 0);
    check("R9 reset sp_a", sp_a, 0);
    rd(8'h01, v); check("R3 reset data", v, 0);

    for (int n = 0; n < NV; n++) begin
      if (VEC[n][24]) wr(VEC[n][23:16], VEC[n][15:8]);
      else begin rd(VEC[n][23:16], v); check("R1 R2 R3 table", v, VEC[n][7:0]); end
    end
    check("R11 sense_dly", sense_dly, 8'h77);
    check("R9 sp_a held", sp_a, 0);
    check("R9 sp_b held", sp_b, 0);

    wr(8'h02, 8'h04);
    check("R4 busy on update", miso, 1);
    check("R5 op update", be_op, 2);
    check("R9 sp_a applied", sp_a, 16'h1234);
    check("R9 sp_b applied", sp_b, 16'hABCD);
    wait_idle();
    check("R4 idle after update", miso, 0);

    wr(8'h00, 8'h10); wr(8'h01, 8'hC3);
    s0 = starts;
    wr(8'h02, 8'h02);
    check("R8 be_addr", be_addr, 8'h10);
    check("R8 be_wdata", be_wdata, 8'hC3);
    check("R5 op write", be_op, 1);
    wr(8'h02, 8'h01);
    check("R6 drop while busy", starts, s0 + 1);
    wait_idle();
    check("R8 memory written", mem[8'h10], 8'hC3);

    lat = 1;
    wr(8'h00, 8'h20); wr(8'h02, 8'hF9);
    wait_idle();
    check("R5 op read", be_op, 0);
    rd(8'h01, v); check("R7 read result", v, 8'h9E);

    s0 = starts;
    wr(8'h02, 8'h00); wr(8'h02, 8'h03); wr(8'h02, 8'h06); wr(8'h02, 8'hF8);
    check("R5 invalid commands", starts, s0);
    check("R4 idle after invalid", miso, 0);

    xfer(8'h81, 8'hFF, 12, v);
    rd(8'h01, v); check("R10 abort second byte", v, 8'h9E);
    xfer(8'h82, 8'h00, 5, v);
    check("R10 abort first byte", starts, s0);
    rd(8'h00, v); check("R10 regs intact", v, 8'h20);
    finish_up();
  end
endmodule